// File: doc/BRIEF.md
# Noise-Shaped Fractional Clock Divider

This block derives a slower clock from one of several parent sources. The division ratio has a whole part and a 12-bit fraction, so the long-run ratio is `int + frac/4096`. Every output period is a whole number of parent cycles. A shaping order picks how that whole number is chosen from period to period:

- **Plain integer mode:** every period has the same length.
- **First-order mode:** each period is one of two adjacent lengths.
- **Second- and third-order modes:** cascaded error-feedback accumulators push the length error to high frequencies. The cost is that single periods spread over a wider window around the mean.

The block runs in one system clock domain. Each parent source appears as a one-cycle tick on `src_tick_i`, and a "parent cycle" is one tick of the selected source. A source mask, fixed at build time, forbids some sources. Every setting is sampled only at the boundary between output periods. An order that would push a period below the 2-cycle floor is lowered automatically. A per-period observation port reports each new period length for verification.

Top module: `frac_clk_divider`

## Requirements
- R1: While reset is asserted, `clk_o` and `per_valid_o` are 0. All accumulators and carry history start from zero after reset.
- R2: Mode code 0 (integer): every period is exactly max(int,2) parent cycles. The fraction has no effect, and the accumulators hold.
- R3: Mode code 1 (first order): each period is int or int+1. Over the first 4096 periods after reset, the total is exactly 4096*int+frac.
- R4: Mode code 2 (second order): the adjustment is c1 + c2 - c2_prev, so each period lies in int-1..int+2. Over the first 4096 periods after reset, the total is 4096*int+frac or one more.
- R5: Mode code 3 (third order): the adjustment is c1 + (c2 - c2_prev) + (c3 - 2*c3_prev + c3_prev2), so each period lies in int-3..int+4. The carries come from three cascaded accumulators, each modulo 4096.
- R6: Clamping keeps every period at 2 parent cycles or more:
  - mode 3 with int below 5 runs as mode 2;
  - mode 2 with int below 3 runs as mode 1;
  - int below 2 is treated as 2.
- R7: Each period starts with `clk_o` high for floor(P/2) parent cycles, then low for the rest of the period.
- R8: Divisor, fraction, mode and source select are sampled only at a period boundary. A period already running keeps its length.
- R9: Only ticks of the selected source count as parent cycles. A source whose bit in the mask is clear (default mask 4'b1011, which forbids source 2) is ignored, and the source in use is kept. The source changes at the next boundary.
- R10: At each started period, `per_valid_o` is high for exactly one system cycle, while `per_len_o` carries that period's length. The pulse is registered in the same clock edge as the boundary.
- R11: If `en_i` is low at a boundary, the block goes idle with `clk_o` low and produces no further pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable, sampled at period boundaries |
| mode_i | input | 2 | Shaping order: 0 integer, 1 first, 2 second, 3 third |
| src_sel_i | input | 2 | Requested parent source index |
| src_tick_i | input | 4 | One tick per parent cycle, one bit per source |
| div_int_i | input | 12 | Whole part of the divisor |
| div_frac_i | input | 12 | Fraction of the divisor in 1/4096 units |
| clk_o | output | 1 | Divided clock |
| per_valid_o | output | 1 | Pulse at each period start |
| per_len_o | output | 13 | Length of the period just started, in parent cycles |

## Verification
The bench goes after the low-divisor corners:
- A third-order request at int 3 must fall back to the second-order window of 2..5. A design without the clamp would ask for periods of 0 or 1 and wrap its counter.
- The 4096-period totals expose a carry combination with a wrong sign or a missing delayed term: the total drifts away from 4096*int+frac.
- A divisor change in the middle of a period, a switch to a forbidden source, and dropping the enable check that settings are taken only at boundaries. A design that samples them early would cut the running period short, or count on a forbidden source.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  typedef enum logic [1:0] {
    MODE_INT  = 2'd0,
    MODE_ORD1 = 2'd1,
    MODE_ORD2 = 2'd2,
    MODE_ORD3 = 2'd3
  } shape_mode_e;

  localparam int unsigned MIN_DIV = 2;
  localparam int unsigned STAGES  = 3;

  // Lowest legal whole divisor.
  function automatic int unsigned floor_div(input int unsigned d);
    return (d < MIN_DIV) ? MIN_DIV : d;
  endfunction

  // Lower the shaping order while its negative swing would break the floor.
  function automatic shape_mode_e clamp_mode(input shape_mode_e req,
                                             input int unsigned d);
    shape_mode_e m;
    m = req;
    if (m == MODE_ORD3 && d < MIN_DIV + 3) m = MODE_ORD2;
    if (m == MODE_ORD2 && d < MIN_DIV + 1) m = MODE_ORD1;
    return m;
  endfunction

  // Signed period adjustment from the cascaded carries and their history.
  function automatic logic signed [3:0] carry_combine(
      input shape_mode_e m, input logic c1, input logic c2, input logic c3,
      input logic c2p, input logic c3p, input logic c3pp);
    int t;
    t = 0;
    if (m != MODE_INT) t += int'(c1);
    if (m == MODE_ORD2 || m == MODE_ORD3) t += int'(c2) - int'(c2p);
    if (m == MODE_ORD3) t += int'(c3) - 2 * int'(c3p) + int'(c3pp);
    return 4'(t);
  endfunction

endpackage

// File: rtl/frac_div_mash.sv
module frac_div_mash
  import frac_div_pkg::*;
#(
  parameter int unsigned FRAC_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  shape_mode_e             mode_i,
  input  logic [FRAC_W-1:0]       frac_i,
  output logic signed [3:0]       adj_o
);

  logic [STAGES-1:0][FRAC_W-1:0] acc_q, acc_nxt;
  logic [STAGES-1:0]             carry;
  logic [FRAC_W:0]               sum_w;
  logic [FRAC_W-1:0]             addend;
  logic                          c2_prev_q, c3_prev_q, c3_prev2_q;

  // Cascade: each stage adds the next value of the stage before it.
  always_comb begin
    addend = frac_i;
    sum_w  = '0;
    for (int k = 0; k < STAGES; k++) begin
      sum_w      = {1'b0, acc_q[k]} + {1'b0, addend};
      acc_nxt[k] = sum_w[FRAC_W-1:0];
      carry[k]   = sum_w[FRAC_W];
      addend     = sum_w[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      c2_prev_q  <= 1'b0;
      c3_prev_q  <= 1'b0;
      c3_prev2_q <= 1'b0;
    end else if (step_i) begin
      acc_q      <= acc_nxt;
      c2_prev_q  <= carry[1];
      c3_prev2_q <= c3_prev_q;
      c3_prev_q  <= carry[2];
    end
  end

  assign adj_o = carry_combine(mode_i, carry[0], carry[1], carry[2],
                               c2_prev_q, c3_prev_q, c3_prev2_q);

  assert_acc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(acc_q));
  assert_ord1_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_i == MODE_ORD1) |-> (adj_o >= 4'sd0 && adj_o <= 4'sd1));
  assert_ord2_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_i == MODE_ORD2) |-> (adj_o >= -4'sd1 && adj_o <= 4'sd2));
  assert_ord3_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_i == MODE_ORD3) |-> (adj_o >= -4'sd3 && adj_o <= 4'sd4));

endmodule

// File: rtl/frac_div_period.sv
module frac_div_period #(
  parameter int unsigned LEN_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [LEN_W-1:0] next_len_i,
  output logic             boundary_o,
  output logic             clk_o,
  output logic             per_valid_o,
  output logic [LEN_W-1:0] per_len_o
);

  logic             run_q;
  logic [LEN_W-1:0] cnt_q, len_q;
  logic [LEN_W-1:0] cnt_inc;
  logic             last_cycle;

  assign cnt_inc    = cnt_q + LEN_W'(1);
  assign last_cycle = (cnt_inc == len_q);
  assign boundary_o = tick_i && (!run_q || last_cycle);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      cnt_q       <= '0;
      len_q       <= LEN_W'(2);
      clk_o       <= 1'b0;
      per_valid_o <= 1'b0;
      per_len_o   <= '0;
    end else begin
      per_valid_o <= 1'b0;
      if (boundary_o) begin
        if (en_i) begin
          run_q       <= 1'b1;
          cnt_q       <= '0;
          len_q       <= next_len_i;
          clk_o       <= 1'b1;
          per_valid_o <= 1'b1;
          per_len_o   <= next_len_i;
        end else begin
          run_q <= 1'b0;
          clk_o <= 1'b0;
        end
      end else if (tick_i && run_q) begin
        cnt_q <= cnt_inc;
        clk_o <= (cnt_inc < (len_q >> 1));
      end
    end
  end

  assert_len_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_valid_o |-> per_len_o >= LEN_W'(2));
  assert_high_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_valid_o |-> clk_o);
  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q < len_q);
  assert_len_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_o |=> $stable(len_q));
  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_valid_o |=> !per_valid_o);
  assert_idle_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !clk_o);

endmodule

// File: rtl/frac_clk_divider.sv
module frac_clk_divider
  import frac_div_pkg::*;
#(
  parameter int unsigned INT_W  = 12,
  parameter int unsigned FRAC_W = 12,
  parameter int unsigned N_SRC  = 4,
  parameter logic [N_SRC-1:0] SRC_OK = 4'b1011,
  localparam int unsigned SRC_W = $clog2(N_SRC),
  localparam int unsigned LEN_W = INT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [SRC_W-1:0]  src_sel_i,
  input  logic [N_SRC-1:0]  src_tick_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic              clk_o,
  output logic              per_valid_o,
  output logic [LEN_W-1:0]  per_len_o
);

  logic [SRC_W-1:0]   src_q;
  logic               tick, boundary, start, step;
  shape_mode_e        mode_eff;
  logic signed [3:0]  adj;
  logic [LEN_W-1:0]   next_len;

  function automatic logic src_allowed(input logic [SRC_W-1:0] s);
    return (32'(s) < N_SRC) && SRC_OK[s];
  endfunction

  assign tick     = src_tick_i[src_q];
  assign start    = boundary && en_i;
  assign mode_eff = clamp_mode(shape_mode_e'(mode_i), 32'(div_int_i));
  assign step     = start && (mode_eff != MODE_INT);
  assign next_len = LEN_W'(int'(floor_div(32'(div_int_i))) + int'(adj));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           src_q <= '0;
    else if (start && src_allowed(src_sel_i)) src_q <= src_sel_i;
  end

  frac_div_mash #(.FRAC_W(FRAC_W)) u_mash (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .mode_i (mode_eff),
    .frac_i (div_frac_i),
    .adj_o  (adj)
  );

  frac_div_period #(.LEN_W(LEN_W)) u_period (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .en_i        (en_i),
    .next_len_i  (next_len),
    .boundary_o  (boundary),
    .clk_o       (clk_o),
    .per_valid_o (per_valid_o),
    .per_len_o   (per_len_o)
  );

  assert_src_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_allowed(src_q));
  assert_src_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary |=> $stable(src_q));

endmodule

// File: tb/sim_frac_clk_divider.sv
module sim_frac_clk_divider;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  sel = 2'd0;
  logic [3:0]  src_tick = 4'hF;
  logic [11:0] dint = 12'd4;
  logic [11:0] dfrac = 12'd0;
  logic        clk_o, per_valid;
  logic [12:0] per_len;

  int n_chk = 0, n_err = 0;
  int cyc = 0, tcnt = 0;
  string cur_req = "R1";

  // Reference model state
  int m_run, m_cnt, m_len, m_src, m_clk, m_valid;
  int a1, a2, a3, c2p, c3p, c3pp;
  // Period statistics taken from the observation port
  int st_cnt, st_sum, st_min, st_max, st_gap, st_last, st_len;

  frac_clk_divider u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .src_sel_i(sel),
    .src_tick_i(src_tick), .div_int_i(dint), .div_frac_i(dfrac),
    .clk_o(clk_o), .per_valid_o(per_valid), .per_len_o(per_len));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Parent tick patterns: source 1 every 2nd cycle, source 3 every 3rd.
  always @(negedge clk) begin
    tcnt++;
    src_tick <= {tcnt % 3 == 0, 1'b1, tcnt % 2 == 0, 1'b1};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_len = 2; m_src = 0; m_clk = 0; m_valid = 0;
      a1 = 0; a2 = 0; a3 = 0; c2p = 0; c3p = 0; c3pp = 0;
    end else begin
      m_valid = 0;
      if (src_tick[m_src]) begin
        if (!m_run || m_cnt == m_len - 1) begin
          if (en) begin
            int m, d, adj, c1, c2, c3;
            m = mode; d = (dint < 2) ? 2 : int'(dint); adj = 0;
            if (sel != 2) m_src = sel;
            if (m == 3 && d < 5) m = 2;
            if (m == 2 && d < 3) m = 1;
            if (m != 0) begin
              a1 += dfrac; c1 = a1 / 4096; a1 %= 4096;
              a2 += a1;    c2 = a2 / 4096; a2 %= 4096;
              a3 += a2;    c3 = a3 / 4096; a3 %= 4096;
              adj = c1;
              if (m >= 2) adj += c2 - c2p;
              if (m == 3) adj += c3 - 2 * c3p + c3pp;
              c3pp = c3p; c3p = c3; c2p = c2;
            end
            m_len = d + adj; m_cnt = 0; m_run = 1; m_clk = 1; m_valid = 1;
          end else begin
            m_run = 0; m_clk = 0;
          end
        end else if (m_run) begin
          m_cnt++;
          m_clk = (m_cnt < m_len / 2) ? 1 : 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    #(CLK_NS/4);
    if (rst_n) begin
      chk(clk_o == m_clk[0], "R7", {"clk_o level in phase ", cur_req}, clk_o, m_clk);
      chk(per_valid == m_valid[0], "R10", {"pulse in phase ", cur_req}, per_valid, m_valid);
      if (per_valid && m_valid != 0)
        chk(int'(per_len) == m_len, cur_req, "period length", per_len, m_len);
      if (per_valid) begin
        st_cnt++; st_sum += per_len; st_len = per_len;
        if (per_len < st_min) st_min = per_len;
        if (per_len > st_max) st_max = per_len;
        st_gap = cyc - st_last; st_last = cyc;
      end
    end
  end

  task automatic clear_stats();
    st_cnt = 0; st_sum = 0; st_min = 1 << 20; st_max = 0; st_gap = 0; st_last = cyc;
  endtask

  task automatic wait_periods(input int n);
    int target;
    target = st_cnt + n;
    while (st_cnt < target) @(negedge clk);
  endtask

  task automatic run_phase(input int m, input int di, input int df, input int s,
                           input int np, input string tag);
    @(negedge clk);
    rst_n = 0; en = 0;
    repeat (3) @(negedge clk);
    mode = m[1:0]; dint = di[11:0]; dfrac = df[11:0]; sel = s[1:0]; cur_req = tag;
    en = 1; clear_stats();
    rst_n = 1;
    wait_periods(np);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(clk_o == 1'b0, "R1", "clk_o in reset", clk_o, 0);
    chk(per_valid == 1'b0, "R1", "pulse in reset", per_valid, 0);

    // R2: integer mode ignores the fraction
    run_phase(0, 5, 777, 0, 50, "R2");
    chk(st_min == 5 && st_max == 5, "R2", "integer period min", st_min, 5);
    // R6: whole part below the floor treated as 2
    run_phase(0, 0, 100, 0, 20, "R6");
    chk(st_min == 2 && st_max == 2, "R6", "floor period", st_max, 2);

    // R3: first order, exact total over 4096 periods
    run_phase(1, 3, 512, 0, 4096, "R3");
    chk(st_min >= 3 && st_max <= 4, "R3", "first-order max", st_max, 4);
    chk(st_sum == 4096 * 3 + 512, "R3", "4096-period total", st_sum, 12800);

    // R4: second order window and total
    run_phase(2, 3, 512, 0, 4096, "R4");
    chk(st_min >= 2, "R4", "second-order min", st_min, 2);
    chk(st_max <= 5, "R4", "second-order max", st_max, 5);
    chk(st_sum == 12800 || st_sum == 12801, "R4", "4096-period total", st_sum, 12800);

    // R5: third order at a high mean divisor
    run_phase(3, 81, 1556, 0, 300, "R5");
    chk(st_min >= 78, "R5", "third-order min", st_min, 78);
    chk(st_max <= 85, "R5", "third-order max", st_max, 85);

    // R6: clamped third order at low divisors
    run_phase(3, 3, 512, 0, 300, "R6");
    chk(st_min >= 2 && st_max <= 5, "R6", "clamp to second order min", st_min, 2);
    run_phase(3, 4, 1000, 0, 300, "R6");
    chk(st_min >= 3 && st_max <= 6, "R6", "clamp at int 4 max", st_max, 6);
    run_phase(2, 2, 3000, 0, 200, "R6");
    chk(st_min >= 2 && st_max <= 3, "R6", "clamp to first order max", st_max, 3);

    // R8: change mid-period
    run_phase(0, 10, 0, 0, 3, "R8");
    repeat (3) @(negedge clk);
    dint = 12'd4;
    wait_periods(1);
    chk(st_gap == 10, "R8", "running period kept", st_gap, 10);
    chk(st_len == 4, "R8", "new length at boundary", st_len, 4);

    // R9: source selection and forbidden source
    run_phase(0, 4, 0, 1, 5, "R9");
    chk(st_gap == 8, "R9", "source 1 gap", st_gap, 8);
    sel = 2'd2;
    wait_periods(3);
    chk(st_gap == 8, "R9", "forbidden source ignored", st_gap, 8);
    sel = 2'd3;
    wait_periods(3);
    chk(st_gap == 12, "R9", "source 3 gap", st_gap, 12);

    // R11: enable dropped
    run_phase(0, 6, 0, 0, 3, "R11");
    en = 0;
    repeat (12) @(negedge clk);
    begin
      int bad;
      bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (clk_o || per_valid) bad++;
      end
      chk(bad == 0, "R11", "idle cycles with activity", bad, 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule